// File: doc/BRIEF.md
# Power Mode and Clock Source Controller

This controller decides how a processor subsystem is clocked. Software-style control inputs choose a clock source and set an idle-enable flag. A one-cycle sleep request stands in for the instruction that puts the core to rest. From these inputs the block picks one of seven operating modes: three run modes, three idle modes and a full sleep. It drives separate clock enables for the CPU domain and the peripheral domain, a select code for an external clock multiplexer, and a status code that names the current mode.

A source change does not take effect while the new source is still unusable. The controller holds the old source and raises a pending flag until the requested source reports ready. The ready input must then stay high for a parameterised settling window before the switch happens. A single wake pulse returns the block from idle or sleep to the run mode of the source that is active at that moment.

Top module: `pmc_top`

## Requirements
- R1: The `src_sel` input maps 00 to primary (index 0), 01 to secondary (index 1), and both 11 and the reserved code 10 to internal (index 2). `src_mux_sel` reports the active source as 00, 01 or 11. `src_ready` bit i belongs to source index i.
- R2: In run mode both `cpu_clk_en` and `per_clk_en` are 1. `mode_code` is 1, 2 or 3 for primary, secondary or internal run.
- R3: A `sleep_req` pulse in run mode with `idle_en`=0 enters sleep at the next clock edge. Sleep sets `mode_code`=0 and drives both clock enables to 0.
- R4: A `sleep_req` pulse in run mode with `idle_en`=1 enters idle at the next clock edge. Idle sets `cpu_clk_en`=0 and `per_clk_en`=1. `mode_code` is 5, 6 or 7 for primary, secondary or internal idle.
- R5: `idle_en` counts only in the cycle where `sleep_req` is high. Later changes to it do not alter an idle or sleep mode that has already been entered. A `sleep_req` that arrives while in idle or sleep has no effect.
- R6: A `wake` pulse in idle or sleep returns to run on the active source at the next edge, with both enables set to 1. A `wake` in run mode has no effect.
- R7: When the requested source differs from the active one, `switch_pending` is 1. Once the requested source's ready bit is high, the switch happens on the (SWITCH_DELAY+1)-th consecutive edge with ready high. `switch_pending` then drops to 0.
- R8: While the requested source's ready bit is low, the active source and `mode_code` stay unchanged and `switch_pending` stays 1.
- R9: After reset the block is in primary run with both enables at 1, `src_mux_sel`=00 and `switch_pending`=0.
- R10: Source switching also proceeds in idle mode, and the idle `mode_code` follows the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Requested clock source code |
| idle_en | input | 1 | Idle (1) or full sleep (0) choice for the next sleep request |
| sleep_req | input | 1 | One-cycle request to leave run mode |
| wake | input | 1 | One-cycle wake-up event |
| src_ready | input | 3 | Per-source running flags, bit i for source index i |
| cpu_clk_en | output | 1 | Clock enable for the CPU domain |
| per_clk_en | output | 1 | Clock enable for the peripheral domain |
| src_mux_sel | output | 2 | Active source code for the clock multiplexer |
| mode_code | output | 3 | Current mode: 0 sleep, 1-3 run, 5-7 idle |
| switch_pending | output | 1 | Requested source differs from the active source |

## Verification
The bench builds the controller with SWITCH_DELAY=2. This keeps the settling window short enough that each switch can be checked edge by edge: two pending cycles, then the change on the third edge. With this value the bench also covers the case where ready is held low for several edges before it rises. It covers a switch started in idle and finished there, and reaching every run and idle code, with one scoreboard entry compared after each clock edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int SRC_COUNT = 3;
  localparam int SEL_W     = 2;
  localparam int MODE_W    = 3;

  typedef enum logic [1:0] {
    PST_RUN   = 2'd0,
    PST_IDLE  = 2'd1,
    PST_SLEEP = 2'd2
  } pstate_e;

  // source index: 0 primary, 1 secondary, 2 internal
  typedef logic [1:0] src_idx_t;

  localparam logic [MODE_W-1:0] MODE_SLEEP = 3'd0;

  function automatic src_idx_t sel_to_idx(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;   // 11 and reserved 10 both mean internal
    endcase
  endfunction

  function automatic logic [SEL_W-1:0] idx_to_sel(input src_idx_t idx);
    case (idx)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/pmc_src_switch.sv
module pmc_src_switch
  import pmc_pkg::*;
#(
  parameter int SWITCH_DELAY = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     src_sel,
  input  logic [SRC_COUNT-1:0] src_ready,
  output src_idx_t             act_idx,
  output logic                 pending
);

  src_idx_t req_idx;
  src_idx_t act_q;
  src_idx_t act_d;
  logic     req_rdy;
  logic     go;

  assign req_idx = sel_to_idx(src_sel);
  assign req_rdy = src_ready[req_idx];
  assign pending = (req_idx != act_q);

  generate
    if (SWITCH_DELAY == 0) begin : g_direct
      assign go = pending && req_rdy;
    end else begin : g_settle
      localparam int CNT_W = $clog2(SWITCH_DELAY + 1);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SWITCH_DELAY);
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W-1:0] cnt_d;

      assign go = pending && req_rdy && (cnt_q == CNT_LAST);

      always_comb begin
        cnt_d = '0;
        if (pending && req_rdy && (cnt_q != CNT_LAST)) begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_comb begin
    act_d = act_q;
    if (go) act_d = req_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 2'd0;
    else        act_q <= act_d;
  end

  assign act_idx = act_q;

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sleep_req,
  input  logic    idle_en,
  input  logic    wake,
  output pstate_e state
);

  pstate_e state_q;
  pstate_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PST_RUN: begin
        if (sleep_req) state_d = idle_en ? PST_IDLE : PST_SLEEP;
      end
      PST_IDLE, PST_SLEEP: begin
        if (wake) state_d = PST_RUN;
      end
      default: state_d = PST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PST_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate
  import pmc_pkg::*;
(
  input  pstate_e           state,
  input  src_idx_t          act_idx,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic [SEL_W-1:0]  src_mux_sel,
  output logic [MODE_W-1:0] mode_code
);

  always_comb begin
    cpu_clk_en  = (state == PST_RUN);
    per_clk_en  = (state != PST_SLEEP);
    src_mux_sel = idx_to_sel(act_idx);
    if (state == PST_SLEEP) mode_code = MODE_SLEEP;
    else mode_code = {(state == PST_IDLE), 2'(act_idx + 2'd1)};
  end

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int SWITCH_DELAY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  src_sel,
  input  logic        idle_en,
  input  logic        sleep_req,
  input  logic        wake,
  input  logic [2:0]  src_ready,
  output logic        cpu_clk_en,
  output logic        per_clk_en,
  output logic [1:0]  src_mux_sel,
  output logic [2:0]  mode_code,
  output logic        switch_pending
);

  src_idx_t act_idx;
  pstate_e  state;

  pmc_src_switch #(.SWITCH_DELAY(SWITCH_DELAY)) u_switch (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .src_ready(src_ready),
    .act_idx  (act_idx),
    .pending  (switch_pending)
  );

  pmc_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep_req(sleep_req),
    .idle_en  (idle_en),
    .wake     (wake),
    .state    (state)
  );

  pmc_clk_gate u_gate (
    .state      (state),
    .act_idx    (act_idx),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .src_mux_sel(src_mux_sel),
    .mode_code  (mode_code)
  );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] src_sel,
  input logic       idle_en,
  input logic       sleep_req,
  input logic       wake,
  input logic [2:0] src_ready,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic [1:0] src_mux_sel,
  input logic [2:0] mode_code,
  input logic       switch_pending
);

  function automatic int sel_index(input logic [1:0] s);
    return (s == 2'b00) ? 0 : (s == 2'b01) ? 1 : 2;
  endfunction

  logic in_run;
  assign in_run = (mode_code != 3'd0) && !mode_code[2];

  assert_sleep_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0) |-> (!cpu_clk_en && !per_clk_en));

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && sleep_req && !idle_en) |=> (mode_code == 3'd0));

  assert_idle_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code[2] |-> (!cpu_clk_en && per_clk_en));

  assert_idle_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && sleep_req && idle_en) |=> mode_code[2]);

  assert_run_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> (per_clk_en && in_run));

  assert_wake_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && wake) |=> (cpu_clk_en && per_clk_en));

  assert_switch_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_mux_sel) |-> $past(src_ready[sel_index(src_sel)]));

  assert_hold_unready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_pending && !src_ready[sel_index(src_sel)]) |=> $stable(src_mux_sel));

endmodule

bind pmc_top pmc_checker u_pmc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_sel       (src_sel),
  .idle_en       (idle_en),
  .sleep_req     (sleep_req),
  .wake          (wake),
  .src_ready     (src_ready),
  .cpu_clk_en    (cpu_clk_en),
  .per_clk_en    (per_clk_en),
  .src_mux_sel   (src_mux_sel),
  .mode_code     (mode_code),
  .switch_pending(switch_pending)
);

// File: tb/test_pmc_top.sv
module test_pmc_top;

  logic       clk;
  logic       rst_n;
  logic [1:0] src_sel;
  logic       idle_en;
  logic       sleep_req;
  logic       wake;
  logic [2:0] src_ready;
  logic       cpu_clk_en;
  logic       per_clk_en;
  logic [1:0] src_mux_sel;
  logic [2:0] mode_code;
  logic       switch_pending;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // packed expectation: {pend, sel[1:0], cpu, per, mode[2:0]}
  logic [7:0] exp_q[$];
  string      tag_q[$];

  pmc_top #(.SWITCH_DELAY(2)) i_pmc_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_sel       (src_sel),
    .idle_en       (idle_en),
    .sleep_req     (sleep_req),
    .wake          (wake),
    .src_ready     (src_ready),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .src_mux_sel   (src_mux_sel),
    .mode_code     (mode_code),
    .switch_pending(switch_pending)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pk(input logic [2:0] m, input logic c,
                                    input logic p, input logic [1:0] s,
                                    input logic pd);
    return {pd, s, c, p, m};
  endfunction

  function automatic logic [7:0] observed();
    return {switch_pending, src_mux_sel, cpu_clk_en, per_clk_en, mode_code};
  endfunction

  task automatic compare(input logic [7:0] exp, input string tag);
    logic [7:0] act;
    act = observed();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual pend=%0b sel=%b cpu=%0b per=%0b mode=%0d, expected pend=%0b sel=%b cpu=%0b per=%0b mode=%0d",
               tag, act[7], act[6:5], act[4], act[3], act[2:0],
               exp[7], exp[6:5], exp[4], exp[3], exp[2:0]);
    end
  endtask

  // driver: queue the result expected after the coming edge, then move to next negedge
  task automatic step(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compare(e, t);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    src_sel   = 2'b00;
    idle_en   = 1'b0;
    sleep_req = 1'b0;
    wake      = 1'b0;
    src_ready = 3'b111;
    #23;
    compare(pk(3'd1, 1, 1, 2'b00, 0), "R9 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    step(pk(3'd1, 1, 1, 2'b00, 0), "R9 primary run after reset");

    // idle entry from primary run
    idle_en = 1'b1; sleep_req = 1'b1;
    step(pk(3'd5, 0, 1, 2'b00, 0), "R4 primary idle");
    sleep_req = 1'b0; idle_en = 1'b0;
    step(pk(3'd5, 0, 1, 2'b00, 0), "R5 idle_en change ignored");
    sleep_req = 1'b1;
    step(pk(3'd5, 0, 1, 2'b00, 0), "R5 sleep_req in idle ignored");
    sleep_req = 1'b0; wake = 1'b1;
    step(pk(3'd1, 1, 1, 2'b00, 0), "R6 wake from idle");
    wake = 1'b0;

    // full sleep
    sleep_req = 1'b1;
    step(pk(3'd0, 0, 0, 2'b00, 0), "R3 sleep entry");
    sleep_req = 1'b0; idle_en = 1'b1;
    step(pk(3'd0, 0, 0, 2'b00, 0), "R5 sleep kept after idle_en set");
    idle_en = 1'b0; wake = 1'b1;
    step(pk(3'd1, 1, 1, 2'b00, 0), "R6 wake from sleep");
    step(pk(3'd1, 1, 1, 2'b00, 0), "R6 wake in run ignored");
    wake = 1'b0;

    // switch to secondary, ready high
    src_sel = 2'b01;
    step(pk(3'd1, 1, 1, 2'b00, 1), "R7 settle edge 1");
    step(pk(3'd1, 1, 1, 2'b00, 1), "R7 settle edge 2");
    step(pk(3'd2, 1, 1, 2'b01, 0), "R7 R2 secondary run");

    // switch to internal while it is not ready
    src_ready = 3'b011; src_sel = 2'b11;
    for (int i = 0; i < 4; i++) step(pk(3'd2, 1, 1, 2'b01, 1), "R8 hold while unready");
    src_ready = 3'b111;
    step(pk(3'd2, 1, 1, 2'b01, 1), "R7 internal settle 1");
    step(pk(3'd2, 1, 1, 2'b01, 1), "R7 internal settle 2");
    step(pk(3'd3, 1, 1, 2'b11, 0), "R2 internal run");

    // reserved code maps to internal
    src_sel = 2'b10;
    step(pk(3'd3, 1, 1, 2'b11, 0), "R1 reserved code is internal");

    // internal idle, then switch to primary while idle
    idle_en = 1'b1; sleep_req = 1'b1;
    step(pk(3'd7, 0, 1, 2'b11, 0), "R4 internal idle");
    sleep_req = 1'b0; src_sel = 2'b00;
    step(pk(3'd7, 0, 1, 2'b11, 1), "R10 idle switch settle 1");
    step(pk(3'd7, 0, 1, 2'b11, 1), "R10 idle switch settle 2");
    step(pk(3'd5, 0, 1, 2'b00, 0), "R10 primary idle after switch");
    wake = 1'b1;
    step(pk(3'd1, 1, 1, 2'b00, 0), "R6 wake to primary run");
    wake = 1'b0;

    // secondary idle
    src_sel = 2'b01;
    step(pk(3'd1, 1, 1, 2'b00, 1), "R7 secondary settle 1");
    step(pk(3'd1, 1, 1, 2'b00, 1), "R7 secondary settle 2");
    step(pk(3'd2, 1, 1, 2'b01, 0), "R1 secondary selected");
    sleep_req = 1'b1;
    step(pk(3'd6, 0, 1, 2'b01, 0), "R4 secondary idle");
    sleep_req = 1'b0; wake = 1'b1;
    step(pk(3'd2, 1, 1, 2'b01, 0), "R6 wake to secondary run");
    wake = 1'b0;

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule